// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block manages a row of general-purpose pins. The pins are grouped into 32-bit banks, and the last bank is only partly filled. Software drives each pin through an output-data word and an output-enable word. It reads the pins back, after synchronisation, through an input-data word. An input-enable word and the output-enable word exclude each other per pin: selecting one direction for a pin drops the other.

Each pin also feeds an event detector. In edge mode it reacts to rising edges, falling edges or both, and each edge type is switched on by writing 0 to its enable bit. In level mode it reacts to a high or a low level, and a separate level-mask bit can turn it off. A detected event sets a sticky status bit, which software clears by writing 1. Pins whose interrupt-mask bit is 0 are ORed into a single registered interrupt request.

The register port is a plain single-cycle interface. A write takes effect on the clock edge where `regWe` is high. A read is combinational from `regAddr`. The word address is `{group[3:0], bank[1:0]}`.

Top module: `gpio_bank_irq`

## Requirements
- R1: A write to group 2 (output data) or group 0 (output enable) of bank b changes `pinOut` or `pinOe` for pins 32b..32b+31 on that clock edge. While `regWe` is low, `pinOut` and `pinOe` do not change. Each word reads back at its own address.
- R2: Writing group 0 clears the matching group-1 (input enable) bits of the written ones. Writing group 1 clears the matching group-0 bits. No pin ever has both set.
- R3: Group 3 (input data, read-only) returns `pinIn` delayed through a two-flop synchroniser. A pin change can be read two rising edges after it is applied.
- R4: With group 4 (mode) bit 0, a pin's status sets on a rising edge when its group-5 bit is 0, and on a falling edge when its group-6 bit is 0. A 1 in either bit disables that edge. The status bit is set on the third rising clock edge after the pin changes.
- R5: Group 9 (status) is write-1-to-clear. Data bits of 0 leave the status unchanged.
- R6: Bank 2 holds only pins 64..92. Bits 29..31 of every bank-2 word read 0, their status never sets, and they never raise `irq`. Bank index 3 reads 0.
- R7: With group 4 bit 1 and group 8 (level mask) bit 0, the status is set every cycle the level is active. The level is high when the group-7 bit is 0 and low when it is 1. A clear issued while the level is still active is lost. A group-8 bit of 1 stops level detection.
- R8: A group-10 (interrupt mask) bit of 1 keeps that pin out of `irq` while its status still latches. `irq` is the registered OR of status AND NOT mask over all banks, and it rises one cycle after the contributing status or unmask.
- R9: After reset, groups 5, 6, 8 and 10 read as all ones over the implemented bits. All other words, `pinOut`, `pinOe` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Word address {group, bank} |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| pinIn | input | 93 | Pin input levels |
| pinOut | output | 93 | Pin output data |
| pinOe | output | 93 | Pin output enables |
| irq | output | 1 | Aggregated interrupt request |

## Verification
A register write is seen on the outputs and on read-back at the first falling edge after its clock edge. An input change can be read two edges later. An event reaches the status bit on the third edge, and `irq` follows one edge after that. The bench drives on falling edges and counts falling edges to land exactly on those cycles. For edges it also checks one cycle early that status is still clear, so a result that comes too soon or too late is caught. For level detection it checks right after writing the clear, where the set must win.

// File: rtl/gbi_pkg.sv
package gbi_pkg;
  localparam int BANK_W     = 32;
  localparam int BANK_SEL_W = 2;
  localparam int GRP_W      = 4;
  localparam int ADDR_W     = GRP_W + BANK_SEL_W;

  localparam logic [GRP_W-1:0] GRP_OE       = 4'd0;
  localparam logic [GRP_W-1:0] GRP_IE       = 4'd1;
  localparam logic [GRP_W-1:0] GRP_DOUT     = 4'd2;
  localparam logic [GRP_W-1:0] GRP_DIN      = 4'd3;
  localparam logic [GRP_W-1:0] GRP_MODE     = 4'd4;
  localparam logic [GRP_W-1:0] GRP_RISE_OFF = 4'd5;
  localparam logic [GRP_W-1:0] GRP_FALL_OFF = 4'd6;
  localparam logic [GRP_W-1:0] GRP_LVL_LOW  = 4'd7;
  localparam logic [GRP_W-1:0] GRP_LVL_MASK = 4'd8;
  localparam logic [GRP_W-1:0] GRP_STATUS   = 4'd9;
  localparam logic [GRP_W-1:0] GRP_IRQ_MASK = 4'd10;

  typedef struct packed {
    logic [BANK_SEL_W-1:0] bank;
    logic oe, ie, dout, mode, riseOff, fallOff, lvlLow, lvlMask, statClr, irqMask;
    logic [BANK_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/gbi_ctrl.sv
module gbi_ctrl
  import gbi_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BANK_W-1:0] regWdata,
  output strobe_t           stb,
  output logic [GRP_W-1:0]  rdGrp,
  output logic [BANK_SEL_W-1:0] rdBank
);
  assign rdGrp  = regAddr[ADDR_W-1:BANK_SEL_W];
  assign rdBank = regAddr[BANK_SEL_W-1:0];

  always_comb begin
    stb      = '0;
    stb.bank = rdBank;
    stb.data = regWdata;
    if (regWe) begin
      case (rdGrp)
        GRP_OE:       stb.oe      = 1'b1;
        GRP_IE:       stb.ie      = 1'b1;
        GRP_DOUT:     stb.dout    = 1'b1;
        GRP_MODE:     stb.mode    = 1'b1;
        GRP_RISE_OFF: stb.riseOff = 1'b1;
        GRP_FALL_OFF: stb.fallOff = 1'b1;
        GRP_LVL_LOW:  stb.lvlLow  = 1'b1;
        GRP_LVL_MASK: stb.lvlMask = 1'b1;
        GRP_STATUS:   stb.statClr = 1'b1;
        GRP_IRQ_MASK: stb.irqMask = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gbi_datapath.sv
module gbi_datapath
  import gbi_pkg::*;
#(
  parameter int NUM_PINS  = 93,
  parameter int NUM_BANKS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [GRP_W-1:0]      rdGrp,
  input  logic [BANK_SEL_W-1:0] rdBank,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [BANK_W-1:0]     regRdata,
  output logic                  irq,
  output logic [NUM_BANKS*BANK_W-1:0] oeVec,
  output logic [NUM_BANKS*BANK_W-1:0] ieVec,
  output logic [NUM_BANKS*BANK_W-1:0] statVec,
  output logic [NUM_BANKS*BANK_W-1:0] imaskVec
);
  localparam int PAD_W = NUM_BANKS * BANK_W;
  localparam logic [PAD_W-1:0] IMPL = PAD_W'({NUM_PINS{1'b1}});

  logic [PAD_W-1:0] oeR, ieR, doutR, modeR, riseOffR, fallOffR;
  logic [PAD_W-1:0] lvlLowR, lvlMaskR, statR, imaskR;
  logic [PAD_W-1:0] sync1, sync2, prevR, pinPad;
  logic [PAD_W-1:0] riseHit, fallHit, lvlHit, evt, selVec, selMasked;

  assign pinPad = PAD_W'(pinIn);

  // two-flop synchroniser plus one history stage for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      prevR <= '0;
    end else begin
      sync1 <= pinPad;
      sync2 <= sync1;
      prevR <= sync2;
    end
  end

  assign riseHit = sync2 & ~prevR & ~riseOffR;
  assign fallHit = ~sync2 & prevR & ~fallOffR;
  assign lvlHit  = modeR & ~lvlMaskR & (sync2 ^ lvlLowR);
  assign evt     = ((~modeR & (riseHit | fallHit)) | lvlHit) & IMPL;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    logic hit;
    assign hit = (int'(stb.bank) == b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        oeR[LO +: BANK_W]      <= '0;
        ieR[LO +: BANK_W]      <= '0;
        doutR[LO +: BANK_W]    <= '0;
        modeR[LO +: BANK_W]    <= '0;
        riseOffR[LO +: BANK_W] <= '1;
        fallOffR[LO +: BANK_W] <= '1;
        lvlLowR[LO +: BANK_W]  <= '0;
        lvlMaskR[LO +: BANK_W] <= '1;
        imaskR[LO +: BANK_W]   <= '1;
        statR[LO +: BANK_W]    <= '0;
      end else begin
        if (hit && stb.oe) begin
          oeR[LO +: BANK_W] <= stb.data;
          ieR[LO +: BANK_W] <= ieR[LO +: BANK_W] & ~stb.data;
        end else if (hit && stb.ie) begin
          ieR[LO +: BANK_W] <= stb.data;
          oeR[LO +: BANK_W] <= oeR[LO +: BANK_W] & ~stb.data;
        end
        if (hit && stb.dout)    doutR[LO +: BANK_W]    <= stb.data;
        if (hit && stb.mode)    modeR[LO +: BANK_W]    <= stb.data;
        if (hit && stb.riseOff) riseOffR[LO +: BANK_W] <= stb.data;
        if (hit && stb.fallOff) fallOffR[LO +: BANK_W] <= stb.data;
        if (hit && stb.lvlLow)  lvlLowR[LO +: BANK_W]  <= stb.data;
        if (hit && stb.lvlMask) lvlMaskR[LO +: BANK_W] <= stb.data;
        if (hit && stb.irqMask) imaskR[LO +: BANK_W]   <= stb.data;
        // a fresh event wins over a clear in the same cycle
        statR[LO +: BANK_W] <= (statR[LO +: BANK_W] &
                                ~((hit && stb.statClr) ? stb.data : '0))
                               | evt[LO +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statR & ~imaskR);
  end

  always_comb begin
    case (rdGrp)
      GRP_OE:       selVec = oeR;
      GRP_IE:       selVec = ieR;
      GRP_DOUT:     selVec = doutR;
      GRP_DIN:      selVec = sync2;
      GRP_MODE:     selVec = modeR;
      GRP_RISE_OFF: selVec = riseOffR;
      GRP_FALL_OFF: selVec = fallOffR;
      GRP_LVL_LOW:  selVec = lvlLowR;
      GRP_LVL_MASK: selVec = lvlMaskR;
      GRP_STATUS:   selVec = statR;
      GRP_IRQ_MASK: selVec = imaskR;
      default:      selVec = '0;
    endcase
    selMasked = selVec & IMPL;
    regRdata  = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(rdBank) == b) regRdata = selMasked[b*BANK_W +: BANK_W];
  end

  assign pinOut   = doutR[NUM_PINS-1:0];
  assign pinOe    = oeR[NUM_PINS-1:0];
  assign oeVec    = oeR;
  assign ieVec    = ieR;
  assign statVec  = statR;
  assign imaskVec = imaskR;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gbi_pkg::*;
#(
  parameter int NUM_PINS = 93
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BANK_W-1:0]   regWdata,
  output logic [BANK_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;

  strobe_t                stb;
  logic [GRP_W-1:0]       rdGrp;
  logic [BANK_SEL_W-1:0]  rdBank;
  logic [PAD_W-1:0]       oeVec, ieVec, statVec, imaskVec;

  gbi_ctrl u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .stb(stb), .rdGrp(rdGrp), .rdBank(rdBank)
  );

  gbi_datapath #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdGrp(rdGrp), .rdBank(rdBank),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .regRdata(regRdata),
    .irq(irq), .oeVec(oeVec), .ieVec(ieVec), .statVec(statVec),
    .imaskVec(imaskVec)
  );
endmodule

// File: rtl/gbi_checker.sv
module gbi_checker
  import gbi_pkg::*;
#(
  parameter int NUM_PINS = 93,
  parameter int PAD_W    = 96
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [BANK_W-1:0]   regWdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irq,
  input logic [PAD_W-1:0]    oeVec,
  input logic [PAD_W-1:0]    ieVec,
  input logic [PAD_W-1:0]    statVec,
  input logic [PAD_W-1:0]    imaskVec
);
  localparam logic [PAD_W-1:0] IMPL = PAD_W'({NUM_PINS{1'b1}});

  a_r1_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(pinOut) && $stable(pinOe)));

  a_r2_dir_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (oeVec & ieVec) == '0);

  a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr[ADDR_W-1:BANK_SEL_W] == GRP_STATUS && regWdata == '0)
    |=> (($past(statVec) & ~statVec) == '0));

  a_r6_spare_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statVec & ~IMPL) == '0);

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&(imaskVec | ~IMPL)) |=> !irq);
endmodule

bind gpio_bank_irq gbi_checker #(.NUM_PINS(NUM_PINS), .PAD_W(PAD_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .pinOut(pinOut), .pinOe(pinOe), .irq(irq),
  .oeVec(oeVec), .ieVec(ieVec), .statVec(statVec), .imaskVec(imaskVec)
);

// File: tb/sim_gpio_bank_irq.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [92:0] pinIn = '0;
  logic [92:0] pinOut, pinOe;
  logic        irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  gpio_bank_irq u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq));

  function automatic logic [31:0] implOf(int b);
    return (b == 2) ? 32'h1fff_ffff : (b > 2) ? 32'h0 : 32'hffff_ffff;
  endfunction
  function automatic logic [31:0] bit32(int n);
    return 32'h1 << n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int grp, int bank, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = {grp[3:0], bank[1:0]}; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(int grp, int bank, output logic [31:0] v);
    regAddr = {grp[3:0], bank[1:0]};
    #1 v = regRdata;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [95:0] pad;
    void'($urandom(32'd1357));
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R9 reset values
    rd(5, 0, v); chk("R9 rise-off reset", v, 32'hffff_ffff);
    rd(6, 1, v); chk("R9 fall-off reset", v, 32'hffff_ffff);
    rd(8, 1, v); chk("R9 level-mask reset", v, 32'hffff_ffff);
    rd(10, 2, v); chk("R9 irq-mask reset bank2", v, implOf(2));
    rd(9, 0, v); chk("R9 status reset", v, 32'h0);
    chk("R9 irq reset", {31'b0, irq}, 32'h0);
    chk("R9 pinOe reset", pinOe[31:0], 32'h0);

    // R1 random output data / enables
    for (int i = 0; i < 6; i++) begin
      int b = int'($urandom % 3);
      logic [31:0] d = $urandom;
      logic [31:0] e = $urandom;
      wr(2, b, d);
      wr(0, b, e);
      pad = {3'b0, pinOut};
      chk("R1 pinOut", pad[b*32 +: 32], d & implOf(b));
      pad = {3'b0, pinOe};
      chk("R1 pinOe", pad[b*32 +: 32], e & implOf(b));
      rd(2, b, v); chk("R1 readback dout", v, d & implOf(b));
    end

    // R2 direction exclusivity
    wr(0, 0, 32'hffff_0000);
    wr(1, 0, 32'h00ff_ff00);
    rd(0, 0, v); chk("R2 oe cleared by ie", v, 32'hff00_0000);
    chk("R2 pinOe", pinOe[31:0], 32'hff00_0000);
    wr(0, 0, 32'h0f0f_0f0f);
    rd(1, 0, v); chk("R2 ie cleared by oe", v, 32'h00f0_f000);

    // R3 random input patterns through the synchroniser
    for (int i = 0; i < 5; i++) begin
      pad = {$urandom, $urandom, $urandom};
      pinIn = pad[92:0];
      waitN(1);
      rd(3, 0, v);
      waitN(1);
      for (int b = 0; b < 3; b++) begin
        rd(3, b, v); chk("R3 input data", v, pad[b*32 +: 32] & implOf(b));
      end
    end
    pinIn = '0;
    waitN(3);
    for (int b = 0; b < 3; b++) begin
      rd(9, b, v); chk("R4 disabled edges leave status", v, 32'h0);
    end

    // R4 rising edge on pin 5, edges enabled by 0
    wr(5, 0, ~bit32(5));
    wr(10, 0, ~bit32(5));
    pinIn[5] = 1'b1;
    waitN(2);
    rd(9, 0, v); chk("R4 status not yet set", v, 32'h0);
    waitN(1);
    rd(9, 0, v); chk("R4 rise latched", v, bit32(5));
    chk("R8 irq before latency", {31'b0, irq}, 32'h0);
    waitN(1);
    chk("R8 irq one cycle after status", {31'b0, irq}, 32'h1);
    // R5 write 0 keeps, write 1 clears
    wr(9, 0, 32'h0);
    rd(9, 0, v); chk("R5 zero write keeps", v, bit32(5));
    wr(9, 0, bit32(5));
    rd(9, 0, v); chk("R5 one write clears", v, 32'h0);
    // falling edge disabled
    pinIn[5] = 1'b0;
    waitN(4);
    rd(9, 0, v); chk("R4 fall disabled", v, 32'h0);
    // both edges
    wr(6, 0, ~bit32(5));
    pinIn[5] = 1'b1;
    waitN(4);
    wr(9, 0, bit32(5));
    pinIn[5] = 1'b0;
    waitN(3);
    rd(9, 0, v); chk("R4 fall latched", v, bit32(5));
    wr(9, 0, 32'hffff_ffff);
    wr(10, 0, 32'hffff_ffff);

    // R7 level mode on pin 40 (bank 1 bit 8)
    pinIn[40] = 1'b1;
    waitN(3);
    wr(4, 1, bit32(8));
    wr(8, 1, ~bit32(8));
    waitN(1);
    rd(9, 1, v); chk("R7 active-high latched", v, bit32(8));
    wr(9, 1, bit32(8));
    rd(9, 1, v); chk("R7 clear lost while active", v, bit32(8));
    chk("R8 masked pin no irq", {31'b0, irq}, 32'h0);
    pinIn[40] = 1'b0;
    waitN(3);
    wr(9, 1, bit32(8));
    rd(9, 1, v); chk("R7 clear after level gone", v, 32'h0);
    wr(7, 1, bit32(8));
    waitN(1);
    rd(9, 1, v); chk("R7 active-low latched", v, bit32(8));
    wr(10, 1, ~bit32(8));
    chk("R8 irq not yet after unmask", {31'b0, irq}, 32'h0);
    waitN(1);
    chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
    wr(8, 1, 32'hffff_ffff);
    wr(9, 1, bit32(8));
    waitN(1);
    rd(9, 1, v); chk("R7 level mask stops detection", v, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);
    wr(10, 1, 32'hffff_ffff);

    // R6 partial last bank
    wr(0, 2, 32'hffff_ffff);
    rd(0, 2, v); chk("R6 oe bank2 spare bits", v, 32'h1fff_ffff);
    chk("R6 pinOe top pins", {3'b0, pinOe[92:64]}, 32'h1fff_ffff);
    wr(5, 2, 32'h0);
    wr(6, 2, 32'h0);
    wr(10, 2, 32'h0);
    pinIn[92] = 1'b1;
    waitN(3);
    rd(9, 2, v); chk("R6 pin 92 latched", v, bit32(28));
    waitN(1);
    chk("R6 pin 92 irq", {31'b0, irq}, 32'h1);
    wr(9, 2, 32'hffff_ffff);
    waitN(2);
    rd(9, 2, v); chk("R6 spare status zero", v, 32'h0);
    chk("R6 spare no irq", {31'b0, irq}, 32'h0);
    rd(0, 3, v); chk("R6 bank 3 reads zero", v, 32'h0);
    wr(10, 2, 32'hffff_ffff);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule